// File: doc/BRIEF.md
# Programmed-I/O Cycle Strobe Timer for a Parallel ATA Channel

The block times one host-side programmed-I/O transfer on a parallel ATA channel. Each transfer runs three phases in a fixed order. First comes address setup. Then the read or write strobe is held active. Last comes a recovery gap. The length of each phase comes from a programmable 4-bit count that holds the number of bus clocks minus one. A field of 0 gives one clock and 0xF gives sixteen.

Two devices share the channel, and each has its own set of timing fields. A device's set has one address-setup count and three timing bytes, one each for 16-bit reads, 16-bit writes and 8-bit register accesses. In a timing byte, the upper nibble is the strobe-active count and the lower nibble is the recovery count.

Software loads the fields through a small write port. A requester starts a transfer by giving a device number, a direction and a width. The block accepts it only when idle, runs the phases, and pulses `done` on the last recovery clock.

The controller has four states, each named here:
- `ST_IDLE` raises `req_ready` and waits.
- `ST_SETUP` drives `addr_phase`.
- `ST_STROBE` drives the read or write strobe.
- `ST_RECOVER` keeps the channel busy with no strobe.

The state changes happen as follows:
- Idle to setup when a request is accepted.
- Setup to strobe when the setup count expires.
- Strobe to recover when the active count expires.
- Recover to idle when the recovery count expires.

Top module: `pio_strobe_timer`

## Requirements
- R1: A timing byte holds the strobe-active count in bits [7:4] and the recovery count in bits [3:0]. A count field value n yields exactly n+1 clocks of its phase.
- R2: The write port selects a field with `cfg_dev` and `cfg_field`. The field codes are 0 for address setup (taken from `cfg_wdata[3:0]`), 1 for the 16-bit read byte, 2 for the 16-bit write byte and 3 for the 8-bit byte. Device 0's setup count sits in bits [3:0] of a shared setup register and device 1's in bits [7:4]. Writing one device's setup count leaves the other device's count unchanged.
- R3: A transfer runs address setup (`addr_phase` high), then strobe-active, then recovery, with no overlap. A strobe is asserted only in the active phase.
- R4: `req_dev` picks which device's timing set a transfer uses, and the two sets are independent.
- R5: A 16-bit read uses the 16-bit read byte and a 16-bit write uses the 16-bit write byte. An 8-bit access (`req_wide`=0) uses the 8-bit byte for either direction.
- R6: After reset every count field is 0xF, so an unprogrammed transfer has 16 setup, 16 active and 16 recovery clocks.
- R7: A request is accepted only while `req_ready` is high, which is only in idle. A request held during a transfer waits until recovery has fully ended, and at least one idle clock separates two transfers.
- R8: `rd_strobe` drives reads (`req_write`=0) and `wr_strobe` drives writes. The two are never high together.
- R9: For a read, `rd_sample` pulses once, on the last clock of the active phase. It never fires for a write.
- R10: The timing fields are captured when a transfer is accepted. A field write made during a transfer changes only later transfers.
- R11: `done` is high for exactly one clock, the final recovery clock, and the block is idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing field write enable |
| cfg_dev | input | 1 | Device whose field is written |
| cfg_field | input | 2 | Field code: 0 setup, 1 16-bit read, 2 16-bit write, 3 8-bit |
| cfg_wdata | input | 8 | Field value; setup uses bits [3:0] |
| req_valid | input | 1 | Transfer request |
| req_dev | input | 1 | Target device of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for 16-bit, 0 for 8-bit access |
| req_ready | output | 1 | Idle and able to accept a request |
| addr_phase | output | 1 | Address setup phase in progress |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| rd_sample | output | 1 | Read data capture pulse |
| cyc_busy | output | 1 | A transfer is in progress |
| done | output | 1 | Final clock of the transfer |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- All-zero counts give the shortest transfer of one clock per phase. An off-by-one counter would lengthen or collapse a phase there.
- With the reset default of 0xF, a wrong reset value or a truncated counter shows up as a phase that is not 16 clocks long.
- A request held high across a transfer catches a design that accepts it during recovery. That design would cut the gap or overlap two transfers.
- A timing write made in the middle of a transfer catches a design that reads the fields live. That design would stretch the running transfer.
- Setup writes to both devices catch a whole-register write that would clobber the neighbouring nibble.
- Mixed directions and widths catch a wrong byte choice.
- Tracking the position of the sample pulse catches a capture that fires at the start of the strobe instead of its end.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } pio_state_e;

    typedef enum logic [1:0] {
        FLD_SETUP  = 2'd0,
        FLD_RD16   = 2'd1,
        FLD_WR16   = 2'd2,
        FLD_NARROW = 2'd3
    } pio_field_e;

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timer_pkg::*;
#(
    parameter int DEV_N  = 2,
    parameter int CNT_W  = 4,
    parameter int DSEL_W = 1,
    localparam int TB_W  = 2 * CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [DSEL_W-1:0]       cfg_dev,
    input  logic [1:0]              cfg_field,
    input  logic [TB_W-1:0]         cfg_wdata,
    output logic [DEV_N*CNT_W-1:0]  setup_all,
    output logic [DEV_N*TB_W-1:0]   rd16_all,
    output logic [DEV_N*TB_W-1:0]   wr16_all,
    output logic [DEV_N*TB_W-1:0]   nar_all
);

    // Shared setup register: one nibble per device, written nibble-wise (R2)
    logic [DEV_N*CNT_W-1:0] setup_q;
    logic [TB_W-1:0]        rd16_q [DEV_N];
    logic [TB_W-1:0]        wr16_q [DEV_N];
    logic [TB_W-1:0]        nar_q  [DEV_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '1;
            for (int d = 0; d < DEV_N; d++) begin
                rd16_q[d] <= '1;
                wr16_q[d] <= '1;
                nar_q[d]  <= '1;
            end
        end else if (cfg_we) begin
            for (int d = 0; d < DEV_N; d++) begin
                if (cfg_dev == DSEL_W'(d)) begin
                    unique case (pio_field_e'(cfg_field))
                        FLD_SETUP:  setup_q[d*CNT_W +: CNT_W] <= cfg_wdata[CNT_W-1:0];
                        FLD_RD16:   rd16_q[d] <= cfg_wdata;
                        FLD_WR16:   wr16_q[d] <= cfg_wdata;
                        FLD_NARROW: nar_q[d]  <= cfg_wdata;
                        default:    ;
                    endcase
                end
            end
        end
    end

    assign setup_all = setup_q;

    for (genvar g = 0; g < DEV_N; g++) begin : g_pack
        assign rd16_all[g*TB_W +: TB_W] = rd16_q[g];
        assign wr16_all[g*TB_W +: TB_W] = wr16_q[g];
        assign nar_all[g*TB_W +: TB_W]  = nar_q[g];
    end

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
    parameter int DEV_N  = 2,
    parameter int CNT_W  = 4,
    parameter int DSEL_W = 1,
    localparam int TB_W  = 2 * CNT_W
) (
    input  logic [DEV_N*CNT_W-1:0] setup_all,
    input  logic [DEV_N*TB_W-1:0]  rd16_all,
    input  logic [DEV_N*TB_W-1:0]  wr16_all,
    input  logic [DEV_N*TB_W-1:0]  nar_all,
    input  logic [DSEL_W-1:0]      req_dev,
    input  logic                   req_write,
    input  logic                   req_wide,
    output logic [CNT_W-1:0]       sel_setup,
    output logic [CNT_W-1:0]       sel_act,
    output logic [CNT_W-1:0]       sel_rec
);

    logic [TB_W-1:0] tbyte;

    always_comb begin
        sel_setup = setup_all[req_dev*CNT_W +: CNT_W];
        // Width picks 16-bit vs 8-bit byte; direction only matters for 16-bit (R5)
        if (req_wide) begin
            tbyte = req_write ? wr16_all[req_dev*TB_W +: TB_W]
                              : rd16_all[req_dev*TB_W +: TB_W];
        end else begin
            tbyte = nar_all[req_dev*TB_W +: TB_W];
        end
        sel_act = tbyte[TB_W-1:CNT_W];
        sel_rec = tbyte[CNT_W-1:0];
    end

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
    import pio_timer_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] sel_setup,
    input  logic [CNT_W-1:0] sel_act,
    input  logic [CNT_W-1:0] sel_rec,
    output logic             req_ready,
    output logic             addr_phase,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             rd_sample,
    output logic             cyc_busy,
    output logic             done
);

    pio_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] act_q, rec_q;
    logic             wr_q;
    logic             accept;
    logic             cnt_zero;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    cnt_d   = sel_setup;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d = ST_STROBE;
                    cnt_d   = act_q;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    state_d = ST_RECOVER;
                    cnt_d   = rec_q;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register; timing captured only at acceptance (R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '1;
            rec_q   <= '1;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                act_q <= sel_act;
                rec_q <= sel_rec;
                wr_q  <= req_write;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        addr_phase = 1'b0;
        rd_strobe  = 1'b0;
        wr_strobe  = 1'b0;
        rd_sample  = 1'b0;
        cyc_busy   = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cyc_busy  = 1'b0;
            end
            ST_SETUP: addr_phase = 1'b1;
            ST_STROBE: begin
                rd_strobe = !wr_q;
                wr_strobe = wr_q;
                rd_sample = !wr_q && cnt_zero;
            end
            ST_RECOVER: done = cnt_zero;
            default: cyc_busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
    parameter int DEV_N  = 2,
    parameter int CNT_W  = 4,
    localparam int DSEL_W = (DEV_N > 1) ? $clog2(DEV_N) : 1,
    localparam int TB_W   = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DSEL_W-1:0] cfg_dev,
    input  logic [1:0]        cfg_field,
    input  logic [TB_W-1:0]   cfg_wdata,
    input  logic              req_valid,
    input  logic [DSEL_W-1:0] req_dev,
    input  logic              req_write,
    input  logic              req_wide,
    output logic              req_ready,
    output logic              addr_phase,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              rd_sample,
    output logic              cyc_busy,
    output logic              done
);

    logic [DEV_N*CNT_W-1:0] setup_all;
    logic [DEV_N*TB_W-1:0]  rd16_all, wr16_all, nar_all;
    logic [CNT_W-1:0]       sel_setup, sel_act, sel_rec;

    pio_timing_regs #(.DEV_N(DEV_N), .CNT_W(CNT_W), .DSEL_W(DSEL_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_dev   (cfg_dev),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .setup_all (setup_all),
        .rd16_all  (rd16_all),
        .wr16_all  (wr16_all),
        .nar_all   (nar_all)
    );

    pio_timing_select #(.DEV_N(DEV_N), .CNT_W(CNT_W), .DSEL_W(DSEL_W)) sel_i (
        .setup_all (setup_all),
        .rd16_all  (rd16_all),
        .wr16_all  (wr16_all),
        .nar_all   (nar_all),
        .req_dev   (req_dev),
        .req_write (req_write),
        .req_wide  (req_wide),
        .sel_setup (sel_setup),
        .sel_act   (sel_act),
        .sel_rec   (sel_rec)
    );

    pio_cycle_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .sel_setup  (sel_setup),
        .sel_act    (sel_act),
        .sel_rec    (sel_rec),
        .req_ready  (req_ready),
        .addr_phase (addr_phase),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .rd_sample  (rd_sample),
        .cyc_busy   (cyc_busy),
        .done       (done)
    );

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic addr_phase,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic rd_sample,
    input logic cyc_busy,
    input logic done
);

    p_excl_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    p_sample_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sample |-> rd_strobe);

    p_sample_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sample |=> !rd_strobe);

    p_setup_to_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> (addr_phase || rd_strobe || wr_strobe));

    p_strobe_to_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |=> (rd_strobe || wr_strobe || (cyc_busy && !addr_phase)));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> addr_phase);

    p_done_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_busy && !addr_phase && !rd_strobe && !wr_strobe));

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

endmodule

bind pio_strobe_timer pio_strobe_timer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .addr_phase (addr_phase),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .rd_sample  (rd_sample),
    .cyc_busy   (cyc_busy),
    .done       (done)
);

// File: tb/pio_strobe_timer_tb_top.sv
module pio_strobe_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_dev = '0;
    logic [1:0] cfg_field = '0;
    logic [7:0] cfg_wdata = '0;
    logic       req_valid = 1'b0;
    logic [0:0] req_dev = '0;
    logic       req_write = 1'b0;
    logic       req_wide = 1'b0;
    logic       req_ready, addr_phase, rd_strobe, wr_strobe, rd_sample, cyc_busy, done;

    always #5 clk = ~clk;

    pio_strobe_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_dev(req_dev), .req_write(req_write), .req_wide(req_wide),
        .req_ready(req_ready), .addr_phase(addr_phase), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .rd_sample(rd_sample), .cyc_busy(cyc_busy), .done(done)
    );

    typedef struct {
        int    s;
        int    a;
        int    r;
        bit    wr;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    // Bench model of the programmed fields (reset default 0xF, R6)
    logic [3:0] m_setup [2] = '{4'hF, 4'hF};
    logic [7:0] m_rd    [2] = '{8'hFF, 8'hFF};
    logic [7:0] m_wr    [2] = '{8'hFF, 8'hFF};
    logic [7:0] m_nar   [2] = '{8'hFF, 8'hFF};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic write_cfg(input int dev, input int fld, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dev = dev[0:0]; cfg_field = fld[1:0]; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            0: m_setup[dev] = val[3:0];
            1: m_rd[dev]    = val;
            2: m_wr[dev]    = val;
            default: m_nar[dev] = val;
        endcase
    endtask

    // Driver: raise the request, wait for idle, push the expected timing at acceptance
    task automatic issue(input int dev, input bit wr, input bit wide, input string tag);
        exp_t       e;
        logic [7:0] tb;
        @(negedge clk);
        req_valid = 1'b1; req_dev = dev[0:0]; req_write = wr; req_wide = wide;
        while (!req_ready) @(negedge clk);
        tb    = wide ? (wr ? m_wr[dev] : m_rd[dev]) : m_nar[dev];
        e.s   = int'(m_setup[dev]) + 1;
        e.a   = int'(tb[7:4]) + 1;
        e.r   = int'(tb[3:0]) + 1;
        e.wr  = wr;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: measure phases and compare on done
    initial begin
        int s = 0, a = 0, r = 0, samples = 0, samp_pos = 0;
        bit saw_rd = 0, saw_wr = 0, prev_done = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                s = 0; a = 0; r = 0; samples = 0; samp_pos = 0;
                saw_rd = 0; saw_wr = 0; prev_done = 0;
            end else begin
                if (prev_done) begin
                    check(req_ready && !cyc_busy && !done, "R7/R11 idle after done",
                          int'(req_ready), 1);
                end
                check(!(rd_strobe && wr_strobe), "R8 exclusive strobes", int'(wr_strobe), 0);
                if (addr_phase) s++;
                if (rd_strobe || wr_strobe) a++;
                if (rd_strobe) saw_rd = 1;
                if (wr_strobe) saw_wr = 1;
                if (rd_sample) begin samples++; samp_pos = a; end
                if (cyc_busy && !addr_phase && !rd_strobe && !wr_strobe) r++;
                prev_done = done;
                if (done) begin
                    if (q.size() == 0) begin
                        check(0, "R11 done without request", 1, 0);
                    end else begin
                        e = q.pop_front();
                        check(s == e.s, {"R2/R3 setup clocks ", e.tag}, s, e.s);
                        check(a == e.a, {"R1/R5 active clocks ", e.tag}, a, e.a);
                        check(r == e.r, {"R1/R3 recovery clocks ", e.tag}, r, e.r);
                        check(saw_wr == e.wr && saw_rd == !e.wr, {"R8 strobe kind ", e.tag},
                              int'(saw_wr), int'(e.wr));
                        check(samples == (e.wr ? 0 : 1), {"R9 sample count ", e.tag},
                              samples, e.wr ? 0 : 1);
                        if (!e.wr)
                            check(samp_pos == a, {"R9 sample on last active clock ", e.tag},
                                  samp_pos, a);
                    end
                    s = 0; a = 0; r = 0; samples = 0; samp_pos = 0;
                    saw_rd = 0; saw_wr = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R7 ready after reset", int'(req_ready), 1);
        check(!rd_strobe && !wr_strobe && !addr_phase && !done && !cyc_busy,
              "R11 outputs quiet after reset", int'(cyc_busy), 0);

        // R6: defaults give 16/16/16
        issue(0, 1'b0, 1'b1, "R6 default dev0 rd16");

        // R2: setup nibbles per device, other untouched
        write_cfg(0, 0, 8'h02);
        write_cfg(1, 0, 8'hF0);   // only [3:0]=0 taken for dev1
        write_cfg(0, 1, 8'h31);
        write_cfg(0, 2, 8'h52);
        write_cfg(0, 3, 8'h04);
        write_cfg(1, 1, 8'h00);
        write_cfg(1, 2, 8'hF0);
        write_cfg(1, 3, 8'h13);

        // R4/R5: each device, direction and width
        issue(0, 1'b0, 1'b1, "R4 dev0 rd16");
        issue(0, 1'b1, 1'b1, "R5 dev0 wr16");
        issue(0, 1'b0, 1'b0, "R5 dev0 rd8");
        issue(0, 1'b1, 1'b0, "R5 dev0 wr8");
        issue(1, 1'b0, 1'b1, "R4 dev1 rd16 minimum");
        issue(1, 1'b1, 1'b1, "R4 dev1 wr16");
        issue(1, 1'b0, 1'b0, "R5 dev1 rd8");

        // R7: request held through a running transfer
        issue(0, 1'b0, 1'b1, "R7 first of pair");
        issue(1, 1'b1, 1'b0, "R7 held request");

        // R10: write during a transfer affects only the next one
        issue(0, 1'b0, 1'b1, "R10 before write");
        write_cfg(0, 1, 8'h77);
        write_cfg(0, 0, 8'h05);
        issue(0, 1'b0, 1'b1, "R10 after write");

        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule